// File: doc/BRIEF.md
# Memory Tag Store Execute Unit

This unit takes one 32-bit instruction word at a time, recognises the memory-tag store operation and carries out its execute step. For the base and source operands it offers register indices to the register file and reads back the values. A separate input carries the current stack pointer. The unit forms the target address from the base and a signed immediate that is scaled to the 16-byte tag granule. It takes a 4-bit allocation tag from the source value and issues one write request to the tag memory. When the addressing form calls for it, it also returns the updated base for writeback.

Three addressing forms share the same opcode and are selected by a 2-bit sub-opcode: post-index, pre-index and plain signed offset. Register index 31 names the stack pointer rather than a general register. When the base is the stack pointer, its alignment is checked first. A fault, or a disabled feature, is reported through a flag and the instruction has no other effect. Every result is registered and appears exactly one cycle after the input valid pulse.

Top module: `tagstore_exec`

## Requirements
- R1: A word counts as this operation only when bits 31:24 are 8'hD9, bits 23:22 are 2'b00 and bit 21 is 1. Any other word gives no tag write, no writeback and no flag.
- R2: Bits 11:10 select the form: 2'b01 is post-index, 2'b11 is pre-index and 2'b10 is signed offset. A value of 2'b00 is treated as a foreign word, with no write and no flag.
- R3: The offset is bits 20:12 read as a two's-complement value and multiplied by 16, which gives a range of -4096 to 4080. Address arithmetic wraps modulo 2^64.
- R4: Post-index writes the tag at the unmodified base and writes base+offset back to the base register.
- R5: Pre-index writes the tag at base+offset and writes that same value back to the base register.
- R6: Signed offset writes the tag at base+offset and performs no writeback.
- R7: Bits 9:5 give the base index and bits 4:0 the source index. Index 31 selects the stack-pointer input for either operand. A base writeback with index 31 is sent on the stack-pointer writeback output instead of the general register writeback output.
- R8: With base index 31 and a stack pointer whose low 4 bits are nonzero, the alignment flag is raised and both the tag write and the writeback are suppressed.
- R9: The tag written is bits 59:56 of the source value. The tag write address is the computed address with its low 4 bits cleared, which names the containing granule.
- R10: With the feature enable low, a word that matches R1 and R2 raises the undefined flag and causes no tag write and no writeback.
- R11: The result-valid output pulses exactly one cycle after each input valid. Reset clears every valid and flag output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | One instruction is presented this cycle |
| insn | input | 32 | Instruction word |
| feat_en | input | 1 | Tag feature enable |
| rf_base_idx | output | 5 | Base register index to the register file |
| rf_src_idx | output | 5 | Source register index to the register file |
| base_rdata | input | 64 | Register file value for the base index |
| src_rdata | input | 64 | Register file value for the source index |
| sp_val | input | 64 | Current stack pointer |
| out_valid | output | 1 | Results below belong to the previous input |
| tag_wr_vld | output | 1 | Tag memory write request |
| tag_wr_addr | output | 64 | Granule-aligned tag write address |
| tag_wr_tag | output | 4 | Allocation tag to store |
| wb_vld | output | 1 | General register writeback |
| sp_wb_vld | output | 1 | Stack pointer writeback |
| wb_idx | output | 5 | Register index for the writeback |
| wb_data | output | 64 | Writeback value |
| undef_flag | output | 1 | Undefined instruction (feature disabled) |
| align_flag | output | 1 | Stack pointer misaligned |

## Verification
All results come from a single register stage. Every flag, the tag write and both writebacks therefore belong to the input valid one rising edge earlier. The bench drives each word just after a falling edge, lets one rising edge pass and then samples all outputs at the next falling edge. In that cycle it also drops the valid, so no two results can overlap. The sweep covers every sub-opcode, boundary immediates, both operand sources, aligned and misaligned stack pointers and both settings of the feature enable. The expected values are worked out arithmetically in the bench.

// File: rtl/tagstore_exec.sv
module tagstore_exec #(
  parameter int XLEN      = 64,
  parameter int GRAN_LOG2 = 4,
  parameter int TAG_W     = 4,
  parameter int TAG_LSB   = 56,
  parameter int IMM_W     = 9,
  parameter int RIDX_W    = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [31:0]       insn,
  input  logic              feat_en,
  output logic [RIDX_W-1:0] rf_base_idx,
  output logic [RIDX_W-1:0] rf_src_idx,
  input  logic [XLEN-1:0]   base_rdata,
  input  logic [XLEN-1:0]   src_rdata,
  input  logic [XLEN-1:0]   sp_val,
  output logic              out_valid,
  output logic              tag_wr_vld,
  output logic [XLEN-1:0]   tag_wr_addr,
  output logic [TAG_W-1:0]  tag_wr_tag,
  output logic              wb_vld,
  output logic              sp_wb_vld,
  output logic [RIDX_W-1:0] wb_idx,
  output logic [XLEN-1:0]   wb_data,
  output logic              undef_flag,
  output logic              align_flag
);
  localparam logic [RIDX_W-1:0] SP_IDX = '1;
  localparam logic [1:0] FORM_POST = 2'b01;
  localparam logic [1:0] FORM_OFFS = 2'b10;
  localparam logic [1:0] FORM_PRE  = 2'b11;

  logic [1:0]       form;
  logic             op_hit, ours;
  logic             base_sp, src_sp, sp_bad;
  logic [IMM_W-1:0] imm;
  logic [XLEN-1:0]  offset, base, src, sum, eff;
  logic             go, do_wb;

  assign op_hit  = (insn[31:24] == 8'hD9) && (insn[23:22] == 2'b00) && insn[21];
  assign form    = insn[11:10];
  assign ours    = in_valid && op_hit && (form != 2'b00);

  assign rf_base_idx = insn[9:5];
  assign rf_src_idx  = insn[4:0];
  assign base_sp     = (rf_base_idx == SP_IDX);
  assign src_sp      = (rf_src_idx == SP_IDX);

  assign imm    = insn[20:12];
  assign offset = {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm} << GRAN_LOG2;

  assign base   = base_sp ? sp_val : base_rdata;
  assign src    = src_sp ? sp_val : src_rdata;
  assign sp_bad = base_sp && (sp_val[GRAN_LOG2-1:0] != '0);

  assign sum    = base + offset;
  assign eff    = (form == FORM_POST) ? base : sum;

  assign go     = ours && feat_en && !sp_bad;
  assign do_wb  = go && (form == FORM_POST || form == FORM_PRE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      tag_wr_vld  <= 1'b0;
      wb_vld      <= 1'b0;
      sp_wb_vld   <= 1'b0;
      undef_flag  <= 1'b0;
      align_flag  <= 1'b0;
      tag_wr_addr <= '0;
      tag_wr_tag  <= '0;
      wb_idx      <= '0;
      wb_data     <= '0;
    end else begin
      out_valid   <= in_valid;
      tag_wr_vld  <= go;
      wb_vld      <= do_wb && !base_sp;
      sp_wb_vld   <= do_wb && base_sp;
      undef_flag  <= ours && !feat_en;
      align_flag  <= ours && feat_en && sp_bad;
      tag_wr_addr <= {eff[XLEN-1:GRAN_LOG2], {GRAN_LOG2{1'b0}}};
      tag_wr_tag  <= src[TAG_LSB +: TAG_W];
      wb_idx      <= rf_base_idx;
      wb_data     <= sum;
    end
  end

  logic unused_form_offs;
  assign unused_form_offs = (form == FORM_OFFS);
endmodule

module tagstore_exec_chk #(
  parameter int XLEN      = 64,
  parameter int GRAN_LOG2 = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            out_valid,
  input logic            tag_wr_vld,
  input logic [XLEN-1:0] tag_wr_addr,
  input logic            wb_vld,
  input logic            sp_wb_vld,
  input logic            undef_flag,
  input logic            align_flag
);
  // R11
  out_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(in_valid));

  // R8
  align_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    align_flag |-> !tag_wr_vld && !wb_vld && !sp_wb_vld);

  // R10
  undef_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    undef_flag |-> !tag_wr_vld && !wb_vld && !sp_wb_vld && !align_flag);

  // R6
  wb_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_vld || sp_wb_vld) |-> tag_wr_vld);

  // R7
  wb_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wb_vld, sp_wb_vld}));

  // R9
  granule_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tag_wr_vld |-> tag_wr_addr[GRAN_LOG2-1:0] == '0);

  // R11
  flags_need_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tag_wr_vld || undef_flag || align_flag) |-> out_valid);
endmodule

bind tagstore_exec tagstore_exec_chk #(.XLEN(XLEN), .GRAN_LOG2(GRAN_LOG2)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_valid(out_valid),
  .tag_wr_vld(tag_wr_vld), .tag_wr_addr(tag_wr_addr), .wb_vld(wb_vld),
  .sp_wb_vld(sp_wb_vld), .undef_flag(undef_flag), .align_flag(align_flag)
);

// File: tb/tagstore_exec_tb.sv
module tagstore_exec_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] insn = '0;
  logic        feat_en = 1'b0;
  logic [4:0]  rf_base_idx, rf_src_idx;
  logic [63:0] base_rdata = '0, src_rdata = '0, sp_val = '0;
  logic        out_valid, tag_wr_vld, wb_vld, sp_wb_vld, undef_flag, align_flag;
  logic [63:0] tag_wr_addr, wb_data;
  logic [3:0]  tag_wr_tag;
  logic [4:0]  wb_idx;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  tagstore_exec dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .insn(insn), .feat_en(feat_en),
    .rf_base_idx(rf_base_idx), .rf_src_idx(rf_src_idx),
    .base_rdata(base_rdata), .src_rdata(src_rdata), .sp_val(sp_val),
    .out_valid(out_valid), .tag_wr_vld(tag_wr_vld), .tag_wr_addr(tag_wr_addr),
    .tag_wr_tag(tag_wr_tag), .wb_vld(wb_vld), .sp_wb_vld(sp_wb_vld),
    .wb_idx(wb_idx), .wb_data(wb_data), .undef_flag(undef_flag), .align_flag(align_flag)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  localparam logic [63:0] GPR_BASE = 64'h0000_0000_0000_0100;
  localparam logic [63:0] GPR_SRC  = 64'hF5A0_1234_0000_0000;
  localparam logic [63:0] SP_OK    = 64'h0700_0012_3456_7890;
  localparam logic [63:0] SP_BAD   = 64'h0700_0012_3456_7898;

  task automatic apply(logic [31:0] w, logic fe, logic [63:0] spv);
    logic        hit, ours, bsp, ssp, bad, go, wb;
    logic [63:0] off, b, s, addr, nb;
    logic [1:0]  f;
    string       rq;
    @(negedge clk);
    insn = w; feat_en = fe; sp_val = spv;
    base_rdata = GPR_BASE; src_rdata = GPR_SRC; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    hit  = (w[31:24] == 8'hD9) && (w[23:22] == 2'b00) && w[21];
    f    = w[11:10];
    ours = hit && (f != 2'b00);
    bsp  = (w[9:5] == 5'd31);
    ssp  = (w[4:0] == 5'd31);
    b    = bsp ? spv : GPR_BASE;
    s    = ssp ? spv : GPR_SRC;
    off  = 64'($signed(w[20:12])) * 64'd16;
    nb   = b + off;
    addr = (f == 2'b01) ? b : nb;
    bad  = bsp && (spv[3:0] != 4'd0);
    go   = ours && fe && !bad;
    wb   = go && (f != 2'b10);
    if (!hit) rq = "R1";
    else if (f == 2'b00) rq = "R2";
    else if (!fe) rq = "R10";
    else if (bad) rq = "R8";
    else if (f == 2'b01) rq = "R4";
    else if (f == 2'b11) rq = "R5";
    else rq = "R6";
    chk("R11", 64'(out_valid), 64'd1);
    chk(rq, 64'(tag_wr_vld), 64'(go));
    chk(rq, 64'(undef_flag), 64'(ours && !fe));
    chk(rq, 64'(align_flag), 64'(ours && fe && bad));
    chk(bsp ? "R7" : rq, 64'(wb_vld), 64'(wb && !bsp));
    chk(bsp ? "R7" : rq, 64'(sp_wb_vld), 64'(wb && bsp));
    if (go) begin
      chk("R3", tag_wr_addr, {addr[63:4], 4'd0});
      chk(ssp ? "R7" : "R9", 64'(tag_wr_tag), 64'(s[59:56]));
    end
    if (wb) begin
      chk(f == 2'b01 ? "R4" : "R5", wb_data, nb);
      chk("R7", 64'(wb_idx), 64'(w[9:5]));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    logic [8:0] imms [6];
    imms = '{9'h000, 9'h001, 9'h1FF, 9'h0FF, 9'h100, 9'h0A5};
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11: reset state
    chk("R11", 64'({out_valid, tag_wr_vld, wb_vld, sp_wb_vld, undef_flag, align_flag}), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11", 64'(out_valid), 64'd0);
    for (int fo = 0; fo < 4; fo++)
      for (int ii = 0; ii < 6; ii++)
        for (int bi = 0; bi < 2; bi++)
          for (int si = 0; si < 2; si++)
            for (int mi = 0; mi < 2; mi++)
              for (int fe = 0; fe < 2; fe++)
                apply({8'hD9, 2'b00, 1'b1, imms[ii], 2'(fo),
                       bi ? 5'd31 : 5'd3, si ? 5'd31 : 5'd7},
                      1'(fe), mi ? SP_BAD : SP_OK);
    // R1: near-miss opcodes
    apply({8'hD9, 2'b01, 1'b1, 9'h010, 2'b11, 5'd3, 5'd7}, 1'b1, SP_OK);
    apply({8'hD9, 2'b00, 1'b0, 9'h010, 2'b11, 5'd3, 5'd7}, 1'b1, SP_OK);
    apply({8'hD8, 2'b00, 1'b1, 9'h010, 2'b01, 5'd3, 5'd7}, 1'b1, SP_OK);
    apply({8'hD9, 2'b00, 1'b1, 9'h010, 2'b01, 5'd3, 5'd7}, 1'b0, SP_OK);
    @(negedge clk);
    // R11: no result without a valid
    chk("R11", 64'({out_valid, tag_wr_vld, undef_flag}), 64'd0);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule